// File: doc/BRIEF.md
# Multi-Mode Microcontroller Port Slice

This block is one 8-bit port slice placed between a microcontroller bus and a group of external pins. Software configures it through a small register write port, and it then runs in one of four behaviours. As plain general-purpose I/O, per-pin direction and data registers drive the pins. As a latched address output, the low or high byte of a multiplexed address/data bus is captured on the address strobe and driven onto the pins that software selects. As an address input latch, the pin values are captured on the strobe and held for downstream address decode. As a peripheral data buffer, the pins carry MCU read and write data to an external 8-bit device, but only while a peripheral select is active.

Two parameters fix the slice's place in the system. `HIGH_PORT` chooses whether the slice carries address byte 0 (address bits 7:0) or byte 1 (address bits 15:8). `BUS_VARIANT` chooses the nibble map: with the standard map every pin can carry its address bit, and with the alternate map a low slice cannot put address bits on pins 3:0. The MCU bus and the configuration port are strobe buses with no back-pressure, so they have no valid/ready handshake. A write is taken on the clock edge where `cfg_we` is high, a strobe is taken on every edge where `bus_ale` is high, and the pin and read-data paths are combinational from the bus controls.

Top module: `mcu_port_slice`

## Requirements
- R1: After reset every register is 0, so `pin_oe` is 0, `bus_rdata_en` is 0, `bus_rdata` is 0 and `addr_in` is 0, and bus writes with a select active drive no pin.
- R2: In general I/O, a pin with direction bit 1 that is not used for address output drives its data-register bit, and a pin with direction bit 0 is not driven.
- R3: On each clock edge with `bus_ale` high the slice captures its address byte from `bus_ad` (bits 7:0 when HIGH_PORT=0, bits 15:8 when HIGH_PORT=1), and holds it while `bus_ale` is low.
- R4: A pin that is available for address output and whose address-enable bit is 1, or whose direction and control bits are both 1, drives the matching bit of the latched address byte.
- R5: With BUS_VARIANT=1 and HIGH_PORT=0, pins 3:0 never carry address bits and behave as general I/O whatever their address-enable and control bits. Pins 7:4 keep the address map, and a high slice keeps the full map.
- R6: With mode bit 0 set, each edge with `bus_ale` high loads `pin_in` into `addr_in`. With the bit clear, or with the strobe low, `addr_in` holds its value.
- R7: With mode bit 7 set and either select bit high, a bus write (`bus_wr`=1) drives all pins with `bus_ad[7:0]`. A bus read alone (`bus_rd`=1, `bus_wr`=0) leaves the pins undriven and returns `pin_in` on `bus_rdata` with `bus_rdata_en`=1. Otherwise `bus_rdata` is 0.
- R8: With mode bit 7 set and both select bits low, no pin is driven and `bus_rdata_en` is 0, whatever the direction, control and address-enable registers hold.
- R9: With mode bit 1 set (data port), general I/O and address output are disabled. The pins follow R7's write and read rules without regard to the select inputs.
- R10: Priority is data port over peripheral buffer over address output over general I/O.
- R11: Register writes use select 0 for data out, 1 for direction, 2 for control, 3 for address enable and 4 for mode. Mode bits are 0 for the address input latch, 1 for the data port and 7 for the peripheral buffer. Selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| bus_ale | input | 1 | Address strobe |
| bus_ad | input | 16 | Multiplexed address/data bus, write data on bits 7:0 |
| bus_rd | input | 1 | MCU read cycle |
| bus_wr | input | 1 | MCU write cycle |
| psel | input | 2 | Peripheral selects, active high |
| pin_in | input | 8 | Pin input values |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| bus_rdata | output | 8 | Read data to the MCU |
| bus_rdata_en | output | 1 | Read data valid, slice drives the bus |
| addr_in | output | 8 | Address byte latched from the pins |

## Verification
A wrong register or latch value reaches the pins in the same cycle that the bench looks at them, because the pin and read paths are combinational. A bad register write therefore shows in `pin_oe` or `pin_out` one clock after the write, and a bad strobe capture shows one clock after the strobe. A mode-priority or select-gating fault shows up as pin drive or read-data enable where none is expected. The bench checks this for every direction pattern, for every address-enable pattern on three instances that differ in nibble map and byte, and for every combination of select and read/write.

// File: rtl/psl_pkg.sv
package psl_pkg;

  // register select codes
  localparam int REG_DOUT = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_CTL  = 2;
  localparam int REG_AOE  = 3;
  localparam int REG_MODE = 4;

  // mode bit positions within the write data
  localparam int MODE_BIT_ADDR_IN   = 0;
  localparam int MODE_BIT_DATA_PORT = 1;
  localparam int MODE_BIT_PERIPH    = 7;

  typedef struct packed {
    logic periph;
    logic data_port;
    logic addr_in;
  } mode_t;

  typedef enum logic [1:0] {
    PM_LOCAL  = 2'd0,  // per-pin address output / general I/O
    PM_PERIPH = 2'd1,
    PM_DATA   = 2'd2
  } port_mode_e;

endpackage

// File: rtl/psl_cfg_regs.sv
module psl_cfg_regs
  import psl_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     ctl_q,
  output logic [W-1:0]     aoe_q,
  output mode_t            mode_q
);

  localparam int NREG = 4;

  logic [W-1:0] regs_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= '0;
        else if (we && sel == SEL_W'(g)) regs_q[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (we && sel == SEL_W'(REG_MODE)) begin
      mode_q.periph    <= wdata[MODE_BIT_PERIPH];
      mode_q.data_port <= wdata[MODE_BIT_DATA_PORT];
      mode_q.addr_in   <= wdata[MODE_BIT_ADDR_IN];
    end
  end

  assign dout_q = regs_q[REG_DOUT];
  assign dir_q  = regs_q[REG_DIR];
  assign ctl_q  = regs_q[REG_CTL];
  assign aoe_q  = regs_q[REG_AOE];

  // R11: selects above the mode register leave every register unchanged
  a_r11_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel > SEL_W'(REG_MODE)) |=>
      ($stable(dout_q) && $stable(dir_q) && $stable(ctl_q) &&
       $stable(aoe_q) && $stable(mode_q)));

  // R11: with no write strobe nothing changes
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mode_q) && $stable(dir_q) && $stable(aoe_q)));

endmodule

// File: rtl/psl_strobe_latch.sv
module psl_strobe_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= d;
  end

  // R3 / R6: the latched byte holds while no capture is requested
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(q));

  // R3 / R6: a capture loads the presented value
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (q == $past(d)));

endmodule

// File: rtl/psl_pin_mux.sv
module psl_pin_mux
  import psl_pkg::*;
#(
  parameter int          W     = 8,
  parameter logic [W-1:0] AVAIL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_t        mode,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] ctl,
  input  logic [W-1:0] aoe,
  input  logic [W-1:0] addr_byte,
  input  logic [1:0]   psel,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rdata,
  output logic         rdata_en
);

  port_mode_e   pmode;
  logic [W-1:0] addr_pin;
  logic [W-1:0] gpio_drv;
  logic         buf_on;

  // R10: data port wins over peripheral buffer, which wins over per-pin use
  always_comb begin
    if (mode.data_port)   pmode = PM_DATA;
    else if (mode.periph) pmode = PM_PERIPH;
    else                  pmode = PM_LOCAL;
  end

  assign addr_pin = AVAIL & (aoe | (dir & ctl));
  assign gpio_drv = dir & ~addr_pin;

  always_comb begin
    unique case (pmode)
      PM_DATA:   buf_on = 1'b1;
      PM_PERIPH: buf_on = |psel;
      default:   buf_on = 1'b0;
    endcase
  end

  always_comb begin
    pin_out  = '0;
    pin_oe   = '0;
    rdata    = '0;
    rdata_en = 1'b0;
    if (pmode == PM_LOCAL) begin
      pin_out = (addr_pin & addr_byte) | (~addr_pin & dout);
      pin_oe  = addr_pin | gpio_drv;
    end else if (buf_on) begin
      if (bus_wr) begin
        pin_out = wdata;
        pin_oe  = '1;
      end else if (bus_rd) begin
        rdata    = pin_in;
        rdata_en = 1'b1;
      end
    end
  end

  // R8: peripheral buffer with no select leaves the pins and bus alone
  a_r8_psel_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.periph && !mode.data_port && psel == 2'b00) |->
      (pin_oe == '0 && !rdata_en));

  // R9: data port drives no pin outside an MCU write
  a_r9_dataport_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.data_port && !bus_wr) |-> (pin_oe == '0));

  // R7: the slice never drives the pins and the read bus together
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |-> (pin_oe == '0 && bus_rd));

  // R2: a pin with direction 0 and no address use stays undriven in local mode
  a_r2_input_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.data_port && !mode.periph) |-> ((pin_oe & ~dir & ~aoe) == '0));

endmodule

// File: rtl/mcu_port_slice.sv
module mcu_port_slice
  import psl_pkg::*;
#(
  parameter int W           = 8,
  parameter int SEL_W       = 3,
  parameter int HIGH_PORT   = 0,
  parameter int BUS_VARIANT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [W-1:0]     cfg_wdata,
  input  logic             bus_ale,
  input  logic [2*W-1:0]   bus_ad,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       psel,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     bus_rdata,
  output logic             bus_rdata_en,
  output logic [W-1:0]     addr_in
);

  localparam int  NIB = W / 2;
  localparam bit  LOW_NIB_BLOCKED = (BUS_VARIANT == 1) && (HIGH_PORT == 0);
  localparam logic [W-1:0] AVAIL =
    LOW_NIB_BLOCKED ? {{(W-NIB){1'b1}}, {NIB{1'b0}}} : {W{1'b1}};

  logic [W-1:0] dout_q, dir_q, ctl_q, aoe_q;
  mode_t        mode_q;
  logic [W-1:0] ad_byte;
  logic [W-1:0] addr_out_q;
  logic         unused_ad;

  psl_cfg_regs #(.W(W), .SEL_W(SEL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .ctl_q  (ctl_q),
    .aoe_q  (aoe_q),
    .mode_q (mode_q)
  );

  generate
    if (HIGH_PORT != 0) begin : g_hi
      assign ad_byte = bus_ad[2*W-1:W];
    end else begin : g_lo
      assign ad_byte = bus_ad[W-1:0];
    end
  endgenerate

  assign unused_ad = ^bus_ad;

  psl_strobe_latch #(.W(W)) u_addr_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (bus_ale),
    .d       (ad_byte),
    .q       (addr_out_q)
  );

  psl_strobe_latch #(.W(W)) u_addr_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (bus_ale & mode_q.addr_in),
    .d       (pin_in),
    .q       (addr_in)
  );

  psl_pin_mux #(.W(W), .AVAIL(AVAIL)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .dout      (dout_q),
    .dir       (dir_q),
    .ctl       (ctl_q),
    .aoe       (aoe_q),
    .addr_byte (addr_out_q),
    .psel      (psel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .wdata     (bus_ad[W-1:0]),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .rdata     (bus_rdata),
    .rdata_en  (bus_rdata_en)
  );

  generate
    if (LOW_NIB_BLOCKED) begin : g_chk_blocked
      // R5: blocked low pins are driven only as general I/O
      a_r5_low_nibble_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.periph && !mode_q.data_port) |->
          ((pin_oe[NIB-1:0] & ~dir_q[NIB-1:0]) == '0 &&
           (pin_out[NIB-1:0] & pin_oe[NIB-1:0]) ==
           (dout_q[NIB-1:0] & pin_oe[NIB-1:0])));
    end
  endgenerate

endmodule

// File: tb/mcu_port_slice_test.sv
module mcu_port_slice_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        bus_ale = 1'b0;
  logic [15:0] bus_ad = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  psel = '0;
  logic [7:0]  pin_in = '0;

  logic [7:0] out0, oe0, rd0, ain0;
  logic       rden0;
  logic [7:0] out1, oe1, rd1, ain1;
  logic       rden1;
  logic [7:0] out2, oe2, rd2, ain2;
  logic       rden2;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  // standard map, low byte
  mcu_port_slice #(.HIGH_PORT(0), .BUS_VARIANT(0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_ale(bus_ale), .bus_ad(bus_ad),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .psel(psel), .pin_in(pin_in),
    .pin_out(out0), .pin_oe(oe0), .bus_rdata(rd0), .bus_rdata_en(rden0),
    .addr_in(ain0));

  // alternate map, low byte
  mcu_port_slice #(.HIGH_PORT(0), .BUS_VARIANT(1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_ale(bus_ale), .bus_ad(bus_ad),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .psel(psel), .pin_in(pin_in),
    .pin_out(out1), .pin_oe(oe1), .bus_rdata(rd1), .bus_rdata_en(rden1),
    .addr_in(ain1));

  // alternate map, high byte (full map expected)
  mcu_port_slice #(.HIGH_PORT(1), .BUS_VARIANT(1)) uut_hi (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_ale(bus_ale), .bus_ad(bus_ad),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .psel(psel), .pin_in(pin_in),
    .pin_out(out2), .pin_oe(oe2), .bus_rdata(rd2), .bus_rdata_en(rden2),
    .addr_in(ain2));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic strobe(input logic [15:0] a);
    @(negedge clk);
    bus_ale = 1'b1; bus_ad = a;
    @(negedge clk);
    bus_ale = 1'b0;
    #1;
  endtask

  // expected local-mode pin behaviour from R2, R4, R5
  function automatic logic [7:0] exp_oe(input logic [7:0] d, c, a, av);
    logic [7:0] ap;
    ap = av & (a | (d & c));
    return ap | (d & ~ap);
  endfunction

  function automatic logic [7:0] exp_out(input logic [7:0] d, c, a, av, ab, dv);
    logic [7:0] ap;
    ap = av & (a | (d & c));
    return ((ap & ab) | (~ap & dv)) & exp_oe(d, c, a, av);
  endfunction

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    chk("R1 oe", {8'h0, oe0}, 16'h0);
    chk("R1 rden", {15'h0, rden0}, 16'h0);
    chk("R1 rdata", {8'h0, rd0}, 16'h0);
    chk("R1 addr_in", {8'h0, ain0}, 16'h0);
    psel = 2'b11; bus_wr = 1'b1; bus_ad = 16'h00FF; #1;
    chk("R1 no buffer after reset", {8'h0, oe0}, 16'h0);
    psel = 2'b00; bus_wr = 1'b0;

    // R2: sweep every direction pattern, control and address enable 0
    wr_reg(3'd0, 8'hA5);
    for (int v = 0; v < 256; v++) begin
      wr_reg(3'd1, 8'(v));
      chk("R2 oe", {8'h0, oe0}, {8'h0, 8'(v)});
      chk("R2 out", {8'h0, out0 & oe0}, {8'h0, 8'hA5 & 8'(v)});
      chk("R2 alt oe", {8'h0, oe1}, {8'h0, 8'(v)});
    end

    // R3/R4/R5: sweep address-enable patterns on three maps
    strobe(16'h3CA5);
    wr_reg(3'd0, 8'h66);
    wr_reg(3'd1, 8'hF0);
    wr_reg(3'd2, 8'h3C);
    for (int a = 0; a < 256; a++) begin
      wr_reg(3'd3, 8'(a));
      chk("R4 std oe", {8'h0, oe0}, {8'h0, exp_oe(8'hF0, 8'h3C, 8'(a), 8'hFF)});
      chk("R4 std out", {8'h0, out0 & oe0},
          {8'h0, exp_out(8'hF0, 8'h3C, 8'(a), 8'hFF, 8'hA5, 8'h66)});
      chk("R5 alt oe", {8'h0, oe1}, {8'h0, exp_oe(8'hF0, 8'h3C, 8'(a), 8'hF0)});
      chk("R5 alt out", {8'h0, out1 & oe1},
          {8'h0, exp_out(8'hF0, 8'h3C, 8'(a), 8'hF0, 8'hA5, 8'h66)});
      chk("R5 high out", {8'h0, out2 & oe2},
          {8'h0, exp_out(8'hF0, 8'h3C, 8'(a), 8'hFF, 8'h3C, 8'h66)});
    end

    // R3: latch holds while strobe low, then recaptures
    @(negedge clk); bus_ad = 16'hFFFF; @(negedge clk); #1;
    chk("R3 hold low", {8'h0, out0}, 16'h00A5);
    chk("R3 hold high", {8'h0, out2}, 16'h003C);
    strobe(16'h5A96);
    chk("R3 low byte", {8'h0, out0}, 16'h0096);
    chk("R3 high byte", {8'h0, out2}, 16'h005A);
    chk("R5 alt blocked oe", {8'h0, oe1}, 16'h00F0);
    chk("R5 alt upper", {12'h0, out1[7:4]}, 16'h0009);

    // R6: address input latch
    wr_reg(3'd4, 8'h01);
    pin_in = 8'hC3;
    strobe(16'h0000);
    chk("R6 capture", {8'h0, ain0}, 16'h00C3);
    pin_in = 8'h11; @(negedge clk); @(negedge clk); #1;
    chk("R6 hold no strobe", {8'h0, ain0}, 16'h00C3);
    wr_reg(3'd4, 8'h00);
    strobe(16'h0000);
    chk("R6 hold mode off", {8'h0, ain0}, 16'h00C3);
    wr_reg(3'd4, 8'h01);
    strobe(16'h0000);
    chk("R6 recapture", {8'h0, ain0}, 16'h0011);

    // R7/R8: peripheral buffer, all selects and all rd/wr pairs
    wr_reg(3'd1, 8'hFF); wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'hFF);
    wr_reg(3'd4, 8'h80);
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 4; op++) begin
        logic sel_on, rd_e, wr_e;
        sel_on = (p != 0); rd_e = op[0]; wr_e = op[1];
        @(negedge clk);
        psel = 2'(p); bus_rd = rd_e; bus_wr = wr_e;
        bus_ad = 16'h00B7; pin_in = 8'h4E;
        #1;
        if (p == 0) begin
          chk("R8 oe no select", {8'h0, oe0}, 16'h0);
          chk("R8 rden no select", {15'h0, rden0}, 16'h0);
        end else begin
          chk("R7 oe", {8'h0, oe0}, (wr_e) ? 16'h00FF : 16'h0);
          chk("R7 out", {8'h0, out0 & oe0}, (wr_e) ? 16'h00B7 : 16'h0);
          chk("R7 rden", {15'h0, rden0}, {15'h0, sel_on & rd_e & ~wr_e});
          chk("R7 rdata", {8'h0, rd0}, (rd_e & ~wr_e) ? 16'h004E : 16'h0);
        end
      end
    end

    // R9/R10: data port ignores selects and wins over the buffer
    for (int m = 0; m < 2; m++) begin
      wr_reg(3'd4, (m == 0) ? 8'h02 : 8'h82);
      for (int op = 0; op < 4; op++) begin
        logic rd_e, wr_e;
        rd_e = op[0]; wr_e = op[1];
        @(negedge clk);
        psel = 2'b00; bus_rd = rd_e; bus_wr = wr_e; bus_ad = 16'h0029;
        #1;
        chk((m == 0) ? "R9 oe" : "R10 oe", {8'h0, oe0}, wr_e ? 16'h00FF : 16'h0);
        chk((m == 0) ? "R9 out" : "R10 out", {8'h0, out0 & oe0},
            wr_e ? 16'h0029 : 16'h0);
        chk((m == 0) ? "R9 rdata" : "R10 rdata", {8'h0, rd0},
            (rd_e & ~wr_e) ? 16'h004E : 16'h0);
      end
    end
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;

    // R10: peripheral buffer wins over address output and general I/O
    wr_reg(3'd4, 8'h80);
    chk("R10 periph over addr", {8'h0, oe0}, 16'h0);

    // R11: unused selects change nothing
    wr_reg(3'd4, 8'h00); wr_reg(3'd1, 8'h00); wr_reg(3'd3, 8'h00);
    wr_reg(3'd5, 8'hFF); wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
    chk("R11 dir/aoe untouched", {8'h0, oe0}, 16'h0);
    @(negedge clk); psel = 2'b01; bus_wr = 1'b1; #1;
    chk("R11 mode untouched", {8'h0, oe0}, 16'h0);
    @(negedge clk); psel = 2'b00; bus_wr = 1'b0;
    wr_reg(3'd1, 8'h0F);
    chk("R11 dir select", {8'h0, oe0}, 16'h000F);

    finish_run();
  end

endmodule